// File: doc/BRIEF.md
# Dual-Issue Pairing Hazard Checker

This block sits at the head of a two-wide in-order issue stage. Each cycle it looks at the two oldest decoded instructions. Each one comes with a valid bit and a 4-bit class code. The block decides whether both may leave, only the older one, or neither. It models the structural resources an instruction claims in its issue cycle:

- the two issue slots;
- integer pipe A, which holds an adder/address generator and a shifter, with only one of the two usable per cycle;
- integer pipe B, which holds an adder, the branch unit and the multiply/divide unit, with only one of the three usable per cycle;
- the data-cache port;
- the floating-point front end, where adder, multiplier and divide/square-root are mutually exclusive.

Long iterative work, such as integer divide and FP divide/square-root, is tracked outside the block. It reaches the block as two busy inputs. Inside, the block keeps only one piece of state: a small counter. It records how many more cycles a store that has already issued keeps the cache port.

Issue is always in order. The younger instruction can only leave together with the older one. The issue outputs are combinational in the current inputs and the registered port counter, so the decode stage can use them in the same cycle.

Top module: `pair_issue_gate`

## Requirements
- R1: `slot1_issue` is high only when `slot0_issue` is high. An invalid older slot issues nothing. An invalid younger slot never issues.
- R2: Class codes 13 (conditional move), 14 (single-dispatch: unknown, multi-op, atomic, sync loop) and 15 (reserved, handled like 14) occupy both issue slots. When either slot carries such a class, `slot1_issue` is low. The older one still issues alone if nothing else blocks it.
- R3: When the older slot is a branch (code 8), `slot1_issue` is low. A branch in the younger slot may pair.
- R4: Pipe A serves one instruction per cycle. Shift (1), FP transfer (12) and the memory classes (load 2, store 3, FP load 4, FP store 5) all need pipe A, so no two of them pair. A simple integer op (0) pairs with any of them by taking pipe B.
- R5: Pipe B serves one instruction per cycle. Multiply/divide (6), HI/LO move (7) and branch (8) need pipe B, so no two of them pair. Two simple integer ops pair, using one adder in each pipe.
- R6: No two memory-class instructions ever issue in the same cycle.
- R7: FP add (9), FP multiply (10) and FP divide/sqrt (11) share one front end, so no two of them pair. Any of them pairs with an integer-side instruction.
- R8: After an integer store issues, memory-class instructions cannot issue in the next cycle. They can issue again in the cycle after that. Non-memory instructions are unaffected.
- R9: After an FP store issues, memory-class instructions cannot issue in the next two cycles.
- R10: While `mdu_busy` is high, classes 6 and 7 cannot issue. While `fdiv_busy` is high, class 11 cannot issue. Each busy input has no effect on other classes.
- R11: A synchronous reset clears the port counter, so a memory instruction can issue in the first cycle after reset, even if a store issued just before reset. A store that is stalled does not restart the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot0_valid | input | 1 | Older instruction present |
| slot0_cls | input | 4 | Class code of older instruction |
| slot1_valid | input | 1 | Younger instruction present |
| slot1_cls | input | 4 | Class code of younger instruction |
| mdu_busy | input | 1 | Integer multiply/divide unit still iterating |
| fdiv_busy | input | 1 | FP divide/sqrt unit still iterating |
| slot0_issue | output | 1 | Older instruction issues this cycle |
| slot1_issue | output | 1 | Younger instruction issues this cycle |

## Verification
The hardest situations to reach are the ones that depend on the port counter. These are a memory op arriving exactly one or two cycles after a store, a store issuing from the younger slot, and a store that is itself stalled and so must not restart the hold. The scoreboard stimulus places these back to back in consecutive cycles, with expectations tied to the issue cycle of the store. It also includes a reset that lands while an FP store hold is still pending.

// File: rtl/pairchk_pkg.sv
package pairchk_pkg;

    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_IALU   = 4'd0,
        CLS_SHIFT  = 4'd1,
        CLS_LOAD   = 4'd2,
        CLS_STORE  = 4'd3,
        CLS_FLOAD  = 4'd4,
        CLS_FSTORE = 4'd5,
        CLS_MULDIV = 4'd6,
        CLS_HILO   = 4'd7,
        CLS_BRANCH = 4'd8,
        CLS_FADD   = 4'd9,
        CLS_FMUL   = 4'd10,
        CLS_FDIV   = 4'd11,
        CLS_FXFER  = 4'd12,
        CLS_CMOV   = 4'd13,
        CLS_SOLO   = 4'd14,
        CLS_RSVD   = 4'd15
    } op_class_e;

    // Resources one instruction claims in its issue cycle
    typedef struct packed {
        logic solo;    // takes both issue slots
        logic pipe_a;  // needs pipe A
        logic pipe_b;  // needs pipe B
        logic flex;    // needs an adder in either pipe
        logic cache;   // needs the cache port
        logic fpu;     // needs the FP front end
        logic mdu;     // blocked by mdu_busy
        logic fdiv;    // blocked by fdiv_busy
        logic branch;  // ends the issue group
        logic st;      // integer store
        logic fst;     // FP store
    } op_need_t;

endpackage

// File: rtl/pairchk_decode.sv
module pairchk_decode
    import pairchk_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output op_need_t         need
);
    always_comb begin
        need = '0;
        unique case (op_class_e'(cls))
            CLS_IALU:   need.flex = 1'b1;
            CLS_SHIFT:  need.pipe_a = 1'b1;
            CLS_LOAD,
            CLS_FLOAD:  begin need.pipe_a = 1'b1; need.cache = 1'b1; end
            CLS_STORE:  begin need.pipe_a = 1'b1; need.cache = 1'b1; need.st = 1'b1; end
            CLS_FSTORE: begin need.pipe_a = 1'b1; need.cache = 1'b1; need.fst = 1'b1; end
            CLS_MULDIV,
            CLS_HILO:   begin need.pipe_b = 1'b1; need.mdu = 1'b1; end
            CLS_BRANCH: begin need.pipe_b = 1'b1; need.branch = 1'b1; end
            CLS_FADD,
            CLS_FMUL:   need.fpu = 1'b1;
            CLS_FDIV:   begin need.fpu = 1'b1; need.fdiv = 1'b1; end
            CLS_FXFER:  need.pipe_a = 1'b1;
            default:    need.solo = 1'b1;
        endcase
    end
endmodule

// File: rtl/pairchk_port_hold.sv
module pairchk_port_hold #(
    parameter int ST_HOLD  = 1,
    parameter int FST_HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic st_issue,
    input  logic fst_issue,
    output logic port_busy
);
    localparam int MAX_HOLD = (ST_HOLD > FST_HOLD) ? ST_HOLD : FST_HOLD;
    localparam int CNT_W    = (MAX_HOLD < 2) ? 1 : $clog2(MAX_HOLD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (fst_issue) begin
            hold_d.cnt = CNT_W'(FST_HOLD);
        end else if (st_issue) begin
            hold_d.cnt = CNT_W'(ST_HOLD);
        end else if (hold_q.cnt != '0) begin
            hold_d.cnt = hold_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign port_busy = (hold_q.cnt != '0);
endmodule

// File: rtl/pairchk_arbiter.sv
module pairchk_arbiter
    import pairchk_pkg::*;
(
    input  op_need_t need0,
    input  op_need_t need1,
    input  logic     valid0,
    input  logic     valid1,
    input  logic     mdu_busy,
    input  logic     fdiv_busy,
    input  logic     port_busy,
    output logic     issue0,
    output logic     issue1
);
    logic       ok0, ok1, fit;
    logic [1:0] cnt_a, cnt_b, cnt_f;

    always_comb begin
        ok0 = valid0 && !(need0.mdu && mdu_busy) && !(need0.fdiv && fdiv_busy)
                     && !(need0.cache && port_busy);
        ok1 = valid1 && !(need1.mdu && mdu_busy) && !(need1.fdiv && fdiv_busy)
                     && !(need1.cache && port_busy);
        cnt_a = 2'(need0.pipe_a) + 2'(need1.pipe_a);
        cnt_b = 2'(need0.pipe_b) + 2'(need1.pipe_b);
        cnt_f = 2'(need0.flex) + 2'(need1.flex);
        fit = (cnt_a <= 2'd1) && (cnt_b <= 2'd1)
           && ((3'(cnt_a) + 3'(cnt_b) + 3'(cnt_f)) <= 3'd2)
           && !(need0.cache && need1.cache)
           && !(need0.fpu && need1.fpu);
        issue0 = ok0;
        issue1 = ok0 && ok1 && fit && !need0.solo && !need1.solo && !need0.branch;
    end
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
    import pairchk_pkg::*;
#(
    parameter int ST_HOLD  = 1,
    parameter int FST_HOLD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot0_valid,
    input  logic [CLS_W-1:0] slot0_cls,
    input  logic             slot1_valid,
    input  logic [CLS_W-1:0] slot1_cls,
    input  logic             mdu_busy,
    input  logic             fdiv_busy,
    output logic             slot0_issue,
    output logic             slot1_issue
);
    localparam int N_SLOT = 2;

    logic [CLS_W-1:0] cls   [N_SLOT];
    op_need_t         need  [N_SLOT];
    logic             issue [N_SLOT];
    logic             port_busy, st_issue, fst_issue;

    assign cls[0] = slot0_cls;
    assign cls[1] = slot1_cls;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_dec
        pairchk_decode u_dec (.cls(cls[s]), .need(need[s]));
    end

    pairchk_arbiter u_arb (
        .need0     (need[0]),
        .need1     (need[1]),
        .valid0    (slot0_valid),
        .valid1    (slot1_valid),
        .mdu_busy  (mdu_busy),
        .fdiv_busy (fdiv_busy),
        .port_busy (port_busy),
        .issue0    (issue[0]),
        .issue1    (issue[1])
    );

    always_comb begin
        st_issue  = 1'b0;
        fst_issue = 1'b0;
        for (int s = 0; s < N_SLOT; s++) begin
            st_issue  = st_issue  | (issue[s] & need[s].st);
            fst_issue = fst_issue | (issue[s] & need[s].fst);
        end
    end

    pairchk_port_hold #(.ST_HOLD(ST_HOLD), .FST_HOLD(FST_HOLD)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .st_issue  (st_issue),
        .fst_issue (fst_issue),
        .port_busy (port_busy)
    );

    assign slot0_issue = issue[0];
    assign slot1_issue = issue[1];
endmodule

// File: rtl/pair_issue_gate_chk.sv
module pair_issue_gate_chk
    import pairchk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CLS_W-1:0] slot0_cls,
    input logic [CLS_W-1:0] slot1_cls,
    input logic             mdu_busy,
    input logic             slot0_issue,
    input logic             slot1_issue
);
    function automatic logic is_mem(input logic [CLS_W-1:0] c);
        return c == CLS_LOAD || c == CLS_STORE || c == CLS_FLOAD || c == CLS_FSTORE;
    endfunction
    function automatic logic is_fp(input logic [CLS_W-1:0] c);
        return c == CLS_FADD || c == CLS_FMUL || c == CLS_FDIV;
    endfunction
    function automatic logic is_solo(input logic [CLS_W-1:0] c);
        return c >= CLS_CMOV;
    endfunction

    logic st_go, fst_go;
    assign st_go  = (slot0_issue && slot0_cls == CLS_STORE)  || (slot1_issue && slot1_cls == CLS_STORE);
    assign fst_go = (slot0_issue && slot0_cls == CLS_FSTORE) || (slot1_issue && slot1_cls == CLS_FSTORE);

    a_r1_in_order: assert property (@(posedge clk) disable iff (rst)
        slot1_issue |-> slot0_issue);
    a_r2_solo_alone: assert property (@(posedge clk) disable iff (rst)
        (is_solo(slot0_cls) || is_solo(slot1_cls)) |-> !slot1_issue);
    a_r3_branch_last: assert property (@(posedge clk) disable iff (rst)
        (slot0_cls == CLS_BRANCH) |-> !slot1_issue);
    a_r6_one_mem: assert property (@(posedge clk) disable iff (rst)
        slot1_issue |-> !(is_mem(slot0_cls) && is_mem(slot1_cls)));
    a_r7_one_fp: assert property (@(posedge clk) disable iff (rst)
        slot1_issue |-> !(is_fp(slot0_cls) && is_fp(slot1_cls)));
    a_r8_store_hold: assert property (@(posedge clk) disable iff (rst)
        st_go |=> !(slot0_issue && is_mem(slot0_cls)));
    a_r9_fstore_hold: assert property (@(posedge clk) disable iff (rst)
        fst_go |=> !(slot0_issue && is_mem(slot0_cls)));
    a_r10_mdu_block: assert property (@(posedge clk) disable iff (rst)
        (mdu_busy && (slot0_cls == CLS_MULDIV || slot0_cls == CLS_HILO)) |-> !slot0_issue);
endmodule

bind pair_issue_gate pair_issue_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot0_cls   (slot0_cls),
    .slot1_cls   (slot1_cls),
    .mdu_busy    (mdu_busy),
    .slot0_issue (slot0_issue),
    .slot1_issue (slot1_issue)
);

// File: tb/pair_issue_gate_tb.sv
`timescale 1ns/1ps
module pair_issue_gate_tb;
    import pairchk_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       v0 = 1'b0, v1 = 1'b0, mb = 1'b0, fb = 1'b0;
    logic [3:0] c0 = '0, c1 = '0;
    logic       i0, i1;

    int n_vec = 0;
    int n_bad = 0;
    logic [1:0] q_exp[$];
    string      q_tag[$];
    logic       done = 1'b0;

    always #2 clk = ~clk;

    pair_issue_gate u_dut (
        .clk(clk), .rst(rst),
        .slot0_valid(v0), .slot0_cls(c0),
        .slot1_valid(v1), .slot1_cls(c1),
        .mdu_busy(mb), .fdiv_busy(fb),
        .slot0_issue(i0), .slot1_issue(i1)
    );

    task automatic drive(input logic a_v0, input op_class_e a_c0,
                         input logic a_v1, input op_class_e a_c1,
                         input logic a_mb, input logic a_fb,
                         input logic e0, input logic e1, input string tag);
        @(posedge clk); #1;
        v0 = a_v0; c0 = a_c0; v1 = a_v1; c1 = a_c1; mb = a_mb; fb = a_fb;
        q_exp.push_back({e0, e1});
        q_tag.push_back(tag);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: compares at the falling edge, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                logic [1:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_vec++;
                if ({i0, i1} !== e) begin
                    n_bad++;
                    $display("FAIL %s: issue={%b,%b} expected={%b,%b}", t, i0, i1, e[1], e[0]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11: counter clear after reset, memory op issues at once
        drive(1, CLS_LOAD,  0, CLS_IALU, 0, 0, 1, 0, "R11 reset state");
        // R1
        drive(0, CLS_IALU,  1, CLS_IALU, 0, 0, 0, 0, "R1 older invalid");
        drive(1, CLS_IALU,  0, CLS_IALU, 0, 0, 1, 0, "R1 younger invalid");
        // R5
        drive(1, CLS_IALU,  1, CLS_IALU, 0, 0, 1, 1, "R5 two adds");
        drive(1, CLS_MULDIV,1, CLS_HILO, 0, 0, 1, 0, "R5 mdu pair");
        drive(1, CLS_MULDIV,1, CLS_BRANCH,0,0, 1, 0, "R5 mdu branch");
        drive(1, CLS_MULDIV,1, CLS_IALU, 0, 0, 1, 1, "R5 mdu add");
        drive(1, CLS_IALU,  1, CLS_MULDIV,0,0, 1, 1, "R5 add mdu");
        // R4
        drive(1, CLS_SHIFT, 1, CLS_SHIFT,0, 0, 1, 0, "R4 two shifts");
        drive(1, CLS_IALU,  1, CLS_SHIFT,0, 0, 1, 1, "R4 add shift");
        drive(1, CLS_SHIFT, 1, CLS_FXFER,0, 0, 1, 0, "R4 shift xfer");
        drive(1, CLS_LOAD,  1, CLS_IALU, 0, 0, 1, 1, "R4 load add");
        // R6
        drive(1, CLS_LOAD,  1, CLS_FLOAD,0, 0, 1, 0, "R6 two loads");
        // R3
        drive(1, CLS_BRANCH,1, CLS_IALU, 0, 0, 1, 0, "R3 branch first");
        drive(1, CLS_IALU,  1, CLS_BRANCH,0,0, 1, 1, "R3 branch second");
        // R2
        drive(1, CLS_CMOV,  1, CLS_IALU, 0, 0, 1, 0, "R2 cmov first");
        drive(1, CLS_IALU,  1, CLS_SOLO, 0, 0, 1, 0, "R2 solo second");
        drive(1, CLS_RSVD,  1, CLS_FADD, 0, 0, 1, 0, "R2 reserved");
        // R7
        drive(1, CLS_FADD,  1, CLS_FMUL, 0, 0, 1, 0, "R7 add mul");
        drive(1, CLS_FDIV,  1, CLS_FADD, 0, 0, 1, 0, "R7 div add");
        drive(1, CLS_FADD,  1, CLS_LOAD, 0, 0, 1, 1, "R7 fadd load");
        drive(1, CLS_IALU,  1, CLS_FMUL, 0, 0, 1, 1, "R7 add fmul");
        // R10
        drive(1, CLS_MULDIV,1, CLS_IALU, 1, 0, 0, 0, "R10 mdu busy");
        drive(1, CLS_IALU,  1, CLS_HILO, 1, 0, 1, 0, "R10 hilo busy");
        drive(1, CLS_FDIV,  1, CLS_IALU, 0, 1, 0, 0, "R10 fdiv busy");
        drive(1, CLS_FDIV,  1, CLS_IALU, 1, 0, 1, 1, "R10 mdu busy no effect");
        drive(1, CLS_MULDIV,1, CLS_FADD, 0, 1, 1, 1, "R10 fdiv busy no effect");
        // R8
        drive(1, CLS_STORE, 0, CLS_IALU, 0, 0, 1, 0, "R8 store");
        drive(1, CLS_LOAD,  0, CLS_IALU, 0, 0, 0, 0, "R8 load held");
        drive(1, CLS_LOAD,  0, CLS_IALU, 0, 0, 1, 0, "R8 load free");
        drive(1, CLS_STORE, 0, CLS_IALU, 0, 0, 1, 0, "R8 store again");
        drive(1, CLS_IALU,  1, CLS_SHIFT,0, 0, 1, 1, "R8 nonmem unaffected");
        drive(1, CLS_IALU,  1, CLS_STORE,0, 0, 1, 1, "R8 store younger");
        drive(1, CLS_FLOAD, 0, CLS_IALU, 0, 0, 0, 0, "R8 fload held");
        drive(1, CLS_FLOAD, 0, CLS_IALU, 0, 0, 1, 0, "R8 fload free");
        // R9
        drive(1, CLS_FSTORE,0, CLS_IALU, 0, 0, 1, 0, "R9 fstore");
        drive(1, CLS_IALU,  1, CLS_LOAD, 0, 0, 1, 0, "R9 younger load held");
        drive(1, CLS_LOAD,  0, CLS_IALU, 0, 0, 0, 0, "R9 load held 2");
        drive(1, CLS_LOAD,  0, CLS_IALU, 0, 0, 1, 0, "R9 load free");
        // R11: stalled store does not restart hold
        drive(1, CLS_STORE, 0, CLS_IALU, 0, 0, 1, 0, "R11 store");
        drive(1, CLS_STORE, 0, CLS_IALU, 0, 0, 0, 0, "R11 store stalled");
        drive(1, CLS_LOAD,  0, CLS_IALU, 0, 0, 1, 0, "R11 no restart");
        // R11: reset during pending FP store hold
        drive(1, CLS_FSTORE,0, CLS_IALU, 0, 0, 1, 0, "R11 fstore before reset");
        @(posedge clk); #1;
        rst = 1'b1; v0 = 1'b0; v1 = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        v0 = 1'b1; c0 = CLS_LOAD;
        q_exp.push_back(2'b10);
        q_tag.push_back("R11 load after reset");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        finish_run();
    end
endmodule